// File: doc/BRIEF.md
# I2C Event Interrupt Flag Controller

This block watches the two lines of an I2C bus and turns what happens on them into sticky event flags for a slave or multi-master engine. It finds START, repeated START and STOP conditions. It counts the SCL falling edges inside each byte frame. At the 8th and 9th counted edge it combines that count with status inputs from the engine: address match, data byte received, addressed, and remaining byte count at zero. Each event sets its own flag.

Every flag has an enable. The single interrupt output is the OR of all flags whose enable is set. A flag still latches while its enable is low. Software clears the event flags by a write-one-to-clear strobe. The receive-buffer-full and receive-interrupt status bits are separate: they are cleared only by a receive-buffer read strobe. The shift register, address comparator and bus drivers are outside this block and show up only as the status inputs.

Top module: `i2c_evt_irq`

## Requirements
- R1: After reset, every flag, `rx_full_o`, `rx_irq_o` and `irq_o` are 0.
- R2: Flag bit 0 sets on a START (SDA falls while SCL is high, bus idle). Bit 1 sets on a repeated START (the same condition while the bus is busy). Bit 2 sets on a STOP (SDA rises while SCL is high), which also makes the bus idle.
- R3: The SCL fall that ends a START or repeated START is not counted. Counted falls run 1 to 9 within a frame and then restart at 1. A START or repeated START restarts the count.
- R4: Bit 3 (address) sets on the 8th counted fall when `mode_tgt_i` and `adr_match_i` are both 1.
- R5: Bit 4 (data write) sets on the 8th counted fall when `mode_tgt_i` and `data_byte_i` are both 1. In that same cycle `rx_full_o` and `rx_irq_o` set.
- R6: Bit 5 (ACK time) sets on the 9th counted fall when `mode_tgt_i` and `addressed_i` are both 1 and SDA was low at the 9th SCL rise.
- R7: Bit 6 (count) sets on the 9th counted fall when `cnt_zero_i` is 1, whatever the mode.
- R8: A flag latches even when its enable is 0. `irq_o` is 1 exactly when some flag and its bit of `irq_en_i` are both 1.
- R9: A 1 in `flag_clr_i[i]` clears flag i on the next clock. It has no effect on `rx_full_o` or `rx_irq_o`.
- R10: `rxb_rd_i` clears `rx_full_o` and `rx_irq_o`. It does not change any flag.
- R11: When a set event and a clear (`flag_clr_i` or `rxb_rd_i`) reach the same bit in the same cycle, the bit ends up at 1.
- R12: When `mode_tgt_i` is 0, bits 3, 4 and 5 and the receive status bits do not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| mode_tgt_i | input | 1 | Engine is in slave or multi-master mode |
| addressed_i | input | 1 | Engine is currently addressed |
| adr_match_i | input | 1 | Current byte matched the address (7-bit, or either 10-bit byte) |
| data_byte_i | input | 1 | Current byte is a received data byte |
| cnt_zero_i | input | 1 | Remaining data-byte counter is zero |
| flag_clr_i | input | 7 | Write-one-to-clear strobe per flag |
| irq_en_i | input | 7 | Interrupt enable per flag |
| rxb_rd_i | input | 1 | Receive-buffer read strobe |
| flags_o | output | 7 | Sticky event flags (bit map as in R2 to R7) |
| rx_full_o | output | 1 | Receive buffer full status |
| rx_irq_o | output | 1 | Receive interrupt status |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land in the same cycle: an edge-triggered set (the 8th SCL fall that raises the address and data-write flags and the receive status) and a clear (the software strobe or the buffer read). The bench counts the two synchroniser stages and the edge-detect register. It raises both clear strobes for exactly the one system-clock cycle in which the fall is being registered. It then expects the address and data-write flags and the receive status at 1, and the previously set START flag at 0. A later clear with no event must then drop each bit, which shows the strobes themselves work.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NF          = 7;
  localparam int CNT_W       = 4;
  localparam int FRAME_FALLS = 9;

  localparam int F_START  = 0;
  localparam int F_RSTART = 1;
  localparam int F_STOP   = 2;
  localparam int F_ADR    = 3;
  localparam int F_WR     = 4;
  localparam int F_ACKT   = 5;
  localparam int F_CNT    = 6;

  localparam int RX_FULL = 0;
  localparam int RX_IRQ  = 1;
  localparam int NRX     = 2;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic fall8;
    logic fall9;
    logic ack;
  } bus_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '1;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '1;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon
  import i2c_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_FALLS - 1);
  localparam logic [CNT_W-1:0] EIGHTH = CNT_W'(FRAME_FALLS - 2);

  logic [1:0] syn, dly;
  logic scl_s, sda_s, scl_d, sda_d;
  logic start_c, stop_c, fall_c, rise_c;
  logic busy_q, armed_q, ack_q;
  logic [CNT_W-1:0] cnt_q;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (syn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly <= 2'b11;
    else         dly <= syn;
  end

  assign scl_s = syn[1];
  assign sda_s = syn[0];
  assign scl_d = dly[1];
  assign sda_d = dly[0];

  assign start_c = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  assign fall_c  = scl_d & ~scl_s;
  assign rise_c  = ~scl_d & scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      if (start_c)     busy_q <= 1'b1;
      else if (stop_c) busy_q <= 1'b0;

      // the fall closing a START carries no bit: count only after a rise
      if (start_c || stop_c) armed_q <= 1'b0;
      else if (rise_c)       armed_q <= 1'b1;

      if (start_c || stop_c)         cnt_q <= '0;
      else if (fall_c && armed_q)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

      if (rise_c && cnt_q == LAST)   ack_q <= ~sda_s;
    end
  end

  always_comb begin
    evt_o.start  = start_c & ~busy_q;
    evt_o.rstart = start_c & busy_q;
    evt_o.stop   = stop_c;
    evt_o.fall8  = fall_c & armed_q & (cnt_q == EIGHTH);
    evt_o.fall9  = fall_c & armed_q & (cnt_q == LAST);
    evt_o.ack    = ack_q;
  end
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_evt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          mode_tgt_i,
  input  logic          addressed_i,
  input  logic          adr_match_i,
  input  logic          data_byte_i,
  input  logic          cnt_zero_i,
  input  logic [NF-1:0] flag_clr_i,
  input  logic [NF-1:0] irq_en_i,
  input  logic          rxb_rd_i,
  output logic [NF-1:0] flags_o,
  output logic          rx_full_o,
  output logic          rx_irq_o,
  output logic          irq_o
);
  bus_evt_t        evt;
  logic [NF-1:0]   flag_set;
  logic [NRX-1:0]  rx_set, rx_clr, rx_q;
  logic            wr_evt;

  i2c_bus_mon #(.SYNC_STAGES(2)) u_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  assign wr_evt = evt.fall8 & mode_tgt_i & data_byte_i;

  always_comb begin
    flag_set           = '0;
    flag_set[F_START]  = evt.start;
    flag_set[F_RSTART] = evt.rstart;
    flag_set[F_STOP]   = evt.stop;
    flag_set[F_ADR]    = evt.fall8 & mode_tgt_i & adr_match_i;
    flag_set[F_WR]     = wr_evt;
    flag_set[F_ACKT]   = evt.fall9 & mode_tgt_i & addressed_i & evt.ack;
    flag_set[F_CNT]    = evt.fall9 & cnt_zero_i;
  end

  i2c_flag_bank #(.N(NF)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (flag_clr_i),
    .q_o   (flags_o)
  );

  assign rx_set = {NRX{wr_evt}};
  assign rx_clr = {NRX{rxb_rd_i}};

  i2c_flag_bank #(.N(NRX)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (rx_set),
    .clr_i (rx_clr),
    .q_o   (rx_q)
  );

  assign rx_full_o = rx_q[RX_FULL];
  assign rx_irq_o  = rx_q[RX_IRQ];
  assign irq_o     = |(flags_o & irq_en_i);
endmodule

// File: rtl/i2c_evt_irq_chk.sv
module i2c_evt_irq_chk
  import i2c_evt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_i,
  input logic          mode_tgt_i,
  input logic          addressed_i,
  input logic          adr_match_i,
  input logic          data_byte_i,
  input logic          cnt_zero_i,
  input logic [NF-1:0] flag_clr_i,
  input logic [NF-1:0] irq_en_i,
  input logic          rxb_rd_i,
  input logic [NF-1:0] flags_o,
  input logic          rx_full_o,
  input logic          rx_irq_o,
  input logic          irq_o
);
  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == '0) |-> !irq_o);

  assert_flags_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & ~flag_clr_i) != '0) |=>
      ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i)));

  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rxb_rd_i) |=> rx_full_o);

  assert_rx_with_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> (flags_o[F_WR] && rx_irq_o));

  assert_adr_mode_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_ADR]) |-> $past(mode_tgt_i));

  assert_ackt_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_ACKT]) |-> $past(mode_tgt_i && addressed_i));
endmodule

bind i2c_evt_irq i2c_evt_irq_chk u_chk (.*);

// File: tb/i2c_evt_irq_bench.sv
module i2c_evt_irq_bench;
  import i2c_evt_pkg::*;

  localparam int H = 5;
  localparam int NV = 8;
  // {mode, addressed, adr_match, data_byte, cnt_zero, sda_at_ack}
  localparam logic [5:0] VEC [NV] = '{
    6'b111000, 6'b100110, 6'b011110, 6'b110101,
    6'b111110, 6'b000000, 6'b110011, 6'b011100
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic mode = 1'b0, addressed = 1'b0, adr_match = 1'b0, data_byte = 1'b0, cnt_zero = 1'b0;
  logic [NF-1:0] clr = '0, en = '0;
  logic rd = 1'b0;
  logic [NF-1:0] flags;
  logic rx_full, rx_irq, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_evt_irq u_i2c_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .mode_tgt_i(mode), .addressed_i(addressed), .adr_match_i(adr_match),
    .data_byte_i(data_byte), .cnt_zero_i(cnt_zero),
    .flag_clr_i(clr), .irq_en_i(en), .rxb_rd_i(rd),
    .flags_o(flags), .rx_full_o(rx_full), .rx_irq_o(rx_irq), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt();
    repeat (H) @(negedge clk);
  endtask

  task automatic do_start();
    sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); scl = 1'b0; wt();
  endtask

  task automatic do_stop();
    sda = 1'b0; wt(); scl = 1'b1; wt(); sda = 1'b1; wt();
  endtask

  task automatic do_bit(input logic b);
    sda = b; wt(); scl = 1'b1; wt(); scl = 1'b0; wt();
  endtask

  task automatic sw_clear(input logic [NF-1:0] m);
    @(negedge clk); clr = m; @(negedge clk); clr = '0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NF-1:0] exp_f;
    repeat (3) @(negedge clk);
    check("R1 flags", flags, 0);
    check("R1 rx", {rx_full, rx_irq}, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1; wt();

    // table walk: one framed byte per vector
    for (int v = 0; v < NV; v++) begin
      {mode, addressed, adr_match, data_byte, cnt_zero} = VEC[v][5:1];
      do_start();
      for (int b = 0; b < 8; b++) do_bit(b[0]);
      do_bit(VEC[v][0]);
      exp_f = '0;
      exp_f[F_START] = 1'b1;
      exp_f[F_ADR]   = VEC[v][5] & VEC[v][3];
      exp_f[F_WR]    = VEC[v][5] & VEC[v][2];
      exp_f[F_ACKT]  = VEC[v][5] & VEC[v][4] & ~VEC[v][0];
      exp_f[F_CNT]   = VEC[v][1];
      check($sformatf("R2 R4 R5 R6 R7 R12 vec%0d flags", v), flags, exp_f);
      check($sformatf("R5 R12 vec%0d rx", v), {rx_full, rx_irq}, {2{exp_f[F_WR]}});
      do_stop();
      exp_f[F_STOP] = 1'b1;
      check($sformatf("R2 vec%0d stop", v), flags, exp_f);
      sw_clear('1); rd_pulse();
    end
    {mode, addressed, adr_match, data_byte, cnt_zero} = '0;

    // R8: flags latch with enables off; irq follows enables
    do_start(); do_stop();
    check("R8 latch no enable", flags, 7'b0000101);
    check("R8 irq off", irq, 0);
    en = 7'b0000100; @(negedge clk);
    check("R8 irq on stop", irq, 1);
    en = 7'b1000000; @(negedge clk);
    check("R8 irq other bit", irq, 0);
    en = '0;
    sw_clear(7'b0000001);
    check("R9 partial clear", flags, 7'b0000100);
    sw_clear('1);

    // R2 R3: repeated START, counter restart mid-frame
    mode = 1'b1; adr_match = 1'b1;
    do_start();
    for (int b = 0; b < 4; b++) do_bit(1'b1);
    sw_clear('1);
    sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); scl = 1'b0; wt();
    check("R2 rstart", flags, 7'b0000010);
    for (int b = 0; b < 7; b++) do_bit(1'b0);
    check("R3 no adr after 7", flags[F_ADR], 0);
    do_bit(1'b0);
    check("R3 R4 adr on 8th", flags[F_ADR], 1);
    do_bit(1'b1);
    do_stop(); sw_clear('1);

    // R11: clear and read land in the set cycle
    data_byte = 1'b1;
    do_start();
    for (int b = 0; b < 7; b++) do_bit(1'b1);
    sda = 1'b0; wt(); scl = 1'b1; wt();
    scl = 1'b0;
    @(negedge clk); @(negedge clk);
    clr = '1; rd = 1'b1;
    @(negedge clk);
    clr = '0; rd = 1'b0;
    check("R11 set beats clear", flags, 7'b0011000);
    check("R11 set beats read", {rx_full, rx_irq}, 2'b11);
    wt();
    sw_clear(7'b0010000);
    check("R9 wr cleared", flags, 7'b0001000);
    check("R9 rx untouched", {rx_full, rx_irq}, 2'b11);
    sw_clear(7'b0001000);
    data_byte = 1'b1;
    do_bit(1'b1);
    do_start();
    for (int b = 0; b < 8; b++) do_bit(1'b0);
    sw_clear(7'b1101111);
    check("R10 pre wr", flags, 7'b0010000);
    rd_pulse();
    check("R10 rx cleared", {rx_full, rx_irq}, 2'b00);
    check("R10 wr kept", flags, 7'b0010000);
    do_bit(1'b0); do_stop();

    finish_run();
  end
endmodule